// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block turns a 32-bit logical address into a physical address by fetching two page-table entries from memory, one after the other. The address is cut into three fields: a 12-bit top index, a 10-bit middle index and a 10-bit byte offset inside a 1 KB page. The top index picks an entry in a directory whose base address and entry count the requester supplies with each request. That directory entry names the base of a second-level table, and the middle index picks the final entry in that table. The final entry gives the frame base. The walker joins that frame base with the unchanged offset to form the physical address.

Each request carries an access kind: read, write or execute. The walker refuses the translation with a fault code in four cases: the top index is outside the directory length, the directory entry is not valid, the leaf entry is not valid, or the leaf entry does not allow the access kind. Memory is reached through one read port with a one-cycle request pulse. The walker then waits for a response strobe, so a response may take any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: The logical address splits into top index = bits [31:20], middle index = bits [19:10] and offset = bits [9:0]. The first read goes to address `ptbr + 4*top`, where `ptbr` is the base value captured with the request.
- R2: The second read goes to address `{dir_entry[31:10], 10'b0} + 4*middle`. In every table entry, bit 0 means valid, bit 1 means writable, bit 2 means executable, and bits [31:10] are the table or frame base.
- R3: When top index >= `ptlr` (the captured 13-bit entry count), the walk ends with fault code 1 and issues no memory read.
- R4: A directory entry with bit 0 clear ends the walk with fault code 2 after exactly one memory read.
- R5: A leaf entry with bit 0 clear ends the walk with fault code 3. This check takes priority over the permission check.
- R6: Access codes are 0 = read, 1 = write, 2 = execute and 3 = read. A write to a leaf with bit 1 clear, or an execute of a leaf with bit 2 clear, ends with fault code 4. A read needs only the valid bit.
- R7: A successful walk pulses `done` with `fault_code` = 0 and `paddr` = `{leaf[31:10], offset}`.
- R8: `mem_rd_en` is a one-cycle pulse for each read. The walker holds its state until `mem_rd_valid` arrives, whatever the response latency.
- R9: A request is taken only while `req_ready` is high, which happens only when the walker is idle. A `req_valid` during a walk is ignored and does not start a second walk.
- R10: `done` and `fault` are one-cycle pulses and are never high together. `req_ready` is high again in the cycle after either pulse.
- R11: After synchronous reset, `req_ready` = 1 and `done`, `fault`, `mem_rd_en` and `fault_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Logical address to translate |
| req_acc | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 read) |
| ptbr | input | 32 | Directory base address, captured with the request |
| ptlr | input | 13 | Directory entry count, captured with the request |
| req_ready | output | 1 | Walker idle and able to take a request |
| mem_rd_en | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Memory response strobe |
| mem_rd_data | input | 32 | Entry returned by memory |
| done | output | 1 | Translation succeeded (one-cycle pulse) |
| fault | output | 1 | Translation refused (one-cycle pulse) |
| fault_code | output | 3 | 0 none, 1 length, 2 bad directory entry, 3 bad leaf, 4 permission |
| paddr | output | 32 | Physical address, valid when `done` pulses |

## Verification
A wrong internal state shows up within one walk. A bad field split or a bad base computation sends `mem_rd_addr` to the wrong word. The model memory then returns a different entry, so `paddr` or `fault_code` is wrong on the very pulse that ends the walk. A stuck or skipped state shows as the wrong number of read pulses, a missing or doubled end pulse, or `req_ready` not coming back in the cycle after the pulse. The bench sweeps directory indexes on both sides of the length limit, every leaf flag combination, all access kinds and response latencies from 0 to 2 extra cycles. It also sends stray requests during busy walks.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_LEN   = 3'd1,
    FLT_OUTER = 3'd2,
    FLT_INNER = 3'd3,
    FLT_PROT  = 3'd4
  } flt_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RDX = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK_LEN,
    ST_READ_OUTER,
    ST_READ_INNER,
    ST_DONE,
    ST_FAULT
  } walk_st_e;

  localparam int PTE_V_BIT = 0;
  localparam int PTE_W_BIT = 1;
  localparam int PTE_X_BIT = 2;

endpackage

// File: rtl/pt_addr_split.sv
module pt_addr_split #(
  parameter int VA_W    = 32,
  parameter int OUTER_W = 12,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 10
) (
  input  logic [VA_W-1:0]    vaddr,
  output logic [OUTER_W-1:0] outer_idx,
  output logic [INNER_W-1:0] inner_idx,
  output logic [OFF_W-1:0]   offset
);
  localparam int INNER_LSB = OFF_W;
  localparam int OUTER_LSB = OFF_W + INNER_W;

  assign offset    = vaddr[OFF_W-1:0];
  assign inner_idx = vaddr[INNER_LSB +: INNER_W];
  assign outer_idx = vaddr[OUTER_LSB +: OUTER_W];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int AW    = 32,
  parameter int IDX_W = 12
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr
);
  localparam int ENTRY_SHIFT = 2;

  logic [AW-1:0] idx_ext;
  assign idx_ext = {{(AW-IDX_W){1'b0}}, idx};
  assign addr    = base + (idx_ext << ENTRY_SHIFT);
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_walker_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  output logic [2:0]       code
);
  always_comb begin
    code = FLT_NONE;
    if (!pte[PTE_V_BIT]) begin
      code = FLT_INNER;
    end else if (acc == ACC_WR && !pte[PTE_W_BIT]) begin
      code = FLT_PROT;
    end else if (acc == ACC_EX && !pte[PTE_X_BIT]) begin
      code = FLT_PROT;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OUTER_W = 12,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 10,
  parameter int PTE_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_acc,
  input  logic [PTE_W-1:0]   ptbr,
  input  logic [OUTER_W:0]   ptlr,
  output logic               req_ready,
  output logic               mem_rd_en,
  output logic [PTE_W-1:0]   mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [PTE_W-1:0]   mem_rd_data,
  output logic               done,
  output logic               fault,
  output logic [2:0]         fault_code,
  output logic [PTE_W-1:0]   paddr
);
  localparam int BASE_W = PTE_W - OFF_W;

  walk_st_e           state;
  logic [VA_W-1:0]    va_q;
  logic [1:0]         acc_q;
  logic [PTE_W-1:0]   ptbr_q;
  logic [OUTER_W:0]   ptlr_q;

  logic [OUTER_W-1:0] outer_idx;
  logic [INNER_W-1:0] inner_idx;
  logic [OFF_W-1:0]   offset;
  logic [PTE_W-1:0]   outer_addr;
  logic [PTE_W-1:0]   inner_base;
  logic [PTE_W-1:0]   inner_addr;
  logic [2:0]         leaf_code;

  pt_addr_split #(.VA_W(VA_W), .OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFF_W(OFF_W)) u_split (
    .vaddr(va_q), .outer_idx(outer_idx), .inner_idx(inner_idx), .offset(offset)
  );

  pt_entry_addr #(.AW(PTE_W), .IDX_W(OUTER_W)) u_outer_addr (
    .base(ptbr_q), .idx(outer_idx), .addr(outer_addr)
  );

  assign inner_base = {mem_rd_data[PTE_W-1:OFF_W], {OFF_W{1'b0}}};

  pt_entry_addr #(.AW(PTE_W), .IDX_W(INNER_W)) u_inner_addr (
    .base(inner_base), .idx(inner_idx), .addr(inner_addr)
  );

  pt_perm_check #(.PTE_W(PTE_W)) u_perm (
    .pte(mem_rd_data), .acc(acc_q), .code(leaf_code)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      va_q        <= '0;
      acc_q       <= '0;
      ptbr_q      <= '0;
      ptlr_q      <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_code  <= FLT_NONE;
      paddr       <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      done      <= 1'b0;
      fault     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            acc_q  <= req_acc;
            ptbr_q <= ptbr;
            ptlr_q <= ptlr;
            state  <= ST_CHECK_LEN;
          end
        end
        ST_CHECK_LEN: begin
          if ({1'b0, outer_idx} >= ptlr_q) begin
            fault      <= 1'b1;
            fault_code <= FLT_LEN;
            state      <= ST_FAULT;
          end else begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= outer_addr;
            state       <= ST_READ_OUTER;
          end
        end
        ST_READ_OUTER: begin
          if (mem_rd_valid) begin
            if (!mem_rd_data[PTE_V_BIT]) begin
              fault      <= 1'b1;
              fault_code <= FLT_OUTER;
              state      <= ST_FAULT;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= inner_addr;
              state       <= ST_READ_INNER;
            end
          end
        end
        ST_READ_INNER: begin
          if (mem_rd_valid) begin
            if (leaf_code != FLT_NONE) begin
              fault      <= 1'b1;
              fault_code <= leaf_code;
              state      <= ST_FAULT;
            end else begin
              done       <= 1'b1;
              fault_code <= FLT_NONE;
              paddr      <= {mem_rd_data[PTE_W-1 -: BASE_W], offset};
              state      <= ST_DONE;
            end
          end
        end
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R10: end pulses last one cycle and never coincide
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r10_fault_pulse: assert property (@(posedge clk) disable iff (rst) fault |=> !fault);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst) !(done && fault));
  a_r10_ready_back: assert property (@(posedge clk) disable iff (rst) (done || fault) |=> req_ready);
  // R8: each read request is a single-cycle pulse
  a_r8_rd_pulse: assert property (@(posedge clk) disable iff (rst) mem_rd_en |=> !mem_rd_en);
  // R9: an accepted request makes the walker busy
  a_r9_busy: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready);
  // R3: a length fault follows the check cycle with no read in flight
  a_r3_len_no_read: assert property (@(posedge clk) disable iff (rst)
    (fault && fault_code == FLT_LEN) |-> !mem_rd_en && $past(!mem_rd_en));
  // R7: success reports no fault code
  a_r7_done_code: assert property (@(posedge clk) disable iff (rst) done |-> fault_code == FLT_NONE);

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [31:0] ptbr = 32'h0040_0000;
  logic [12:0] ptlr = 13'd4096;
  logic        req_ready;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        done;
  logic        fault;
  logic [2:0]  fault_code;
  logic [31:0] paddr;

  int n_vec = 0;
  int n_bad = 0;
  int lat = 0;
  int pend_cnt = 0;
  logic [31:0] pend_addr = '0;

  localparam logic [31:0] DIR_BASE  = 32'h0040_0000;
  localparam logic [31:0] LEAF_AREA = 32'h0100_0000;

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .ptbr(ptbr), .ptlr(ptlr), .req_ready(req_ready), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .done(done), .fault(fault), .fault_code(fault_code), .paddr(paddr)
  );

  function automatic logic [31:0] dir_entry(int i);
    logic [31:0] b;
    b = LEAF_AREA + (i << 12);
    return {b[31:10], 7'b0, 2'b00, (i % 5 != 3)};
  endfunction

  function automatic logic [31:0] leaf_entry(int i, int j);
    logic [21:0] fr;
    logic [31:0] s;
    s  = i * 37 + j * 11 + 5;
    fr = s[21:0];
    return {fr, 7'b0, j[1], j[0], (j % 7 != 6)};
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    if (a >= DIR_BASE && a < DIR_BASE + 32'h4000)
      return dir_entry(int'((a - DIR_BASE) >> 2));
    if (a >= LEAF_AREA && a < LEAF_AREA + 32'h0100_0000)
      return leaf_entry(int'((a - LEAF_AREA) >> 12), int'(a[11:2]));
    return 32'hDEAD_0000;
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt <= pend_cnt - 1;
      if (pend_cnt == 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem_word(pend_addr);
      end
    end else if (mem_rd_en) begin
      if (lat == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem_word(mem_rd_addr);
      end else begin
        pend_cnt  <= lat;
        pend_addr <= mem_rd_addr;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input bit spam);
    int top, mid, exp_code, exp_reads, reads;
    logic [31:0] de, le, exp_pa, got_pa;
    logic [2:0] got_code;
    bit seen, got_done;
    top = int'(va[31:20]);
    mid = int'(va[19:10]);
    exp_pa = '0;
    if (top >= int'(ptlr)) begin
      exp_code = 1; exp_reads = 0;
    end else begin
      de = dir_entry(top);
      if (!de[0]) begin
        exp_code = 2; exp_reads = 1;
      end else begin
        exp_reads = 2;
        le = leaf_entry(top, mid);
        if (!le[0]) exp_code = 3;
        else if (acc == 2'd1 && !le[1]) exp_code = 4;
        else if (acc == 2'd2 && !le[2]) exp_code = 4;
        else begin exp_code = 0; exp_pa = {le[31:10], va[9:0]}; end
      end
    end
    @(negedge clk);
    check(req_ready, "R9 ready before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    reads = 0; seen = 0; got_done = 0; got_code = '0; got_pa = '0;
    for (int c = 0; c < 80 && !seen; c++) begin
      if (mem_rd_en) reads++;
      if (done || fault) begin
        seen = 1; got_done = done; got_code = fault_code; got_pa = paddr;
        check(!(done && fault), "R10 done and fault together", {30'b0, done, fault}, 32'd0);
      end else begin
        req_valid = spam && (c == 0);
        req_vaddr = ~va;
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    check(seen, "R8 walk ended", {31'b0, seen}, 32'd1);
    case (exp_code)
      1: check(got_code == 3'd1 && !got_done, "R3 length fault", {29'b0, got_code}, 32'd1);
      2: check(got_code == 3'd2 && !got_done, "R4 directory invalid", {29'b0, got_code}, 32'd2);
      3: check(got_code == 3'd3 && !got_done, "R5 leaf invalid", {29'b0, got_code}, 32'd3);
      4: check(got_code == 3'd4 && !got_done, "R6 permission", {29'b0, got_code}, 32'd4);
      default: begin
        check(got_done && got_code == 3'd0, "R7 done code", {28'b0, got_done, got_code}, 32'h8);
        check(got_pa == exp_pa, "R7 physical address (R1 R2 addressing)", got_pa, exp_pa);
      end
    endcase
    check(reads == exp_reads, exp_code == 1 ? "R3 no read on length fault" : "R8 read count",
          reads, exp_reads);
    @(negedge clk);
    check(!done && !fault && req_ready && !mem_rd_en, "R10 pulse end and ready",
          {28'b0, done, fault, req_ready, mem_rd_en}, 32'h2);
    @(negedge clk);
    check(req_ready && !mem_rd_en, "R9 stray request ignored", {30'b0, req_ready, mem_rd_en}, 32'h2);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int tops[11] = '{0, 1, 2, 3, 4, 7, 8, 9, 10, 11, 4095};
    logic [31:0] va;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready && !done && !fault && !mem_rd_en && fault_code == 3'd0, "R11 reset state",
          {27'b0, req_ready, done, fault, mem_rd_en, |fault_code}, 32'h10);
    rst = 1'b0;
    for (int ph = 0; ph < 3; ph++) begin
      ptlr = (ph == 0) ? 13'd4096 : (ph == 1) ? 13'd10 : 13'd0;
      for (int k = 0; k < 11; k++) begin
        for (int j = 0; j < 14; j++) begin
          for (int a = 0; a < 4; a++) begin
            if (ph == 2 && j > 1) continue;
            va = {tops[k][11:0], j[9:0], 10'(tops[k] * 97 + j * 13 + a * 5)};
            lat = (tops[k] + j + a) % 3;
            walk(va, a[1:0], j == 5);
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule